// File: doc/BRIEF.md
# Fast System Call State Unit

This unit keeps the processor state behind the fast ring-transition instructions. It holds three model-specific registers: the kernel code selector, the kernel stack pointer and the kernel entry address. Software reaches them through an indexed register port. The index comes from the ECX value. Write data arrives as a high/low pair from EDX:EAX, and read data is returned the same way.

When the sequencer issues an enter request, the unit produces the new code selector, stack selector, instruction pointer, stack pointer and privilege level for the kernel. On an exit request it produces the same set for user mode, taking the pointers from the EDX and ECX general-register values. All four selectors derive from the single programmed code selector at fixed offsets of 0, 8, 16 and 24. The unit never pushes a return address and has no memory port.

The unit applies the privilege rules and raises a fault instead of a transfer when a rule is broken. Descriptor fetch, decode and the architectural register file sit outside the unit.

Top module: `sysfast_unit`

## Requirements
- R1: While reset is low and on the first cycle after it, every output is zero. All three model-specific registers read back as zero after reset.
- R2: A write to index 0x174 keeps bits [15:0] of the low data word as the kernel code selector. A write to 0x175 keeps the low word as the kernel stack pointer, and a write to 0x176 keeps the low word as the entry address. The high data word is ignored. A read of a valid index returns a high word of zero and the register in the low word, with the selector zero-extended.
- R3: A read or write of any index other than 0x174–0x176 sets `msr_fault` high for one cycle. Such a read returns zero, and such a write changes no register.
- R4: Read data appears one cycle after `msr_rd`. A read and a write of the same index in the same cycle return the value from before the write.
- R5: On a granted enter, one cycle later `xfer_valid` is 1, `new_cs` is the code selector, `new_ss` is the code selector plus 8 (16-bit wrap), `new_eip` and `new_esp` are the entry address and stack pointer, and `new_cpl` is 0.
- R6: On a granted exit, one cycle later `new_cs` is the code selector plus 16 and `new_ss` is the code selector plus 24, each with bits [1:0] forced to 3. `new_eip` takes `gpr_edx`, `new_esp` takes `gpr_ecx`, and `new_cpl` is 3.
- R7: An exit requested while `cpl_in` is not 0 gives `xfer_fault` one cycle later with no `xfer_valid`, and all transfer outputs keep their previous values.
- R8: An enter or exit while bits [15:3] of the code selector are zero gives `xfer_fault` one cycle later with no `xfer_valid`, and all transfer outputs keep their previous values.
- R9: When enter and exit are requested together, only the enter is performed.
- R10: An enter in the same cycle as a register write uses the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_wr | input | 1 | Register write strobe |
| msr_rd | input | 1 | Register read strobe |
| msr_idx | input | 32 | Register index (ECX value) |
| msr_wdata_hi | input | 32 | Write data, high word (EDX) |
| msr_wdata_lo | input | 32 | Write data, low word (EAX) |
| msr_rdata_hi | output | 32 | Read data, high word |
| msr_rdata_lo | output | 32 | Read data, low word |
| msr_fault | output | 1 | Invalid index pulse |
| enter_req | input | 1 | Kernel entry request |
| exit_req | input | 1 | User return request |
| cpl_in | input | 2 | Current privilege level |
| gpr_edx | input | 32 | Return address for exit |
| gpr_ecx | input | 32 | Return stack pointer for exit |
| xfer_valid | output | 1 | Transfer outputs updated this cycle |
| xfer_fault | output | 1 | Transfer refused |
| new_cs | output | 16 | New code selector |
| new_ss | output | 16 | New stack selector |
| new_eip | output | 32 | New instruction pointer |
| new_esp | output | 32 | New stack pointer |
| new_cpl | output | 2 | New privilege level |

## Verification
Every result of this unit is registered. Read data, the index fault, the transfer outputs and the transfer fault are all due on the first rising edge after the request. The bench applies each request just after a falling edge and removes it at the next falling edge. It reads the outputs at that same falling edge, which falls half a period after the edge where they were loaded. The bench never waits an extra cycle, so a result that arrives late or early shows up as a mismatch.

// File: rtl/sysfast_unit.sv
module sysfast_unit #(
  parameter int XLEN = 32,
  parameter int SEL_W = 16,
  parameter int IDX_W = 32,
  parameter int RPL_W = 2,
  parameter logic [IDX_W-1:0] IDX_CS  = 'h174,
  parameter logic [IDX_W-1:0] IDX_ESP = 'h175,
  parameter logic [IDX_W-1:0] IDX_EIP = 'h176,
  parameter int SS_OFF = 8,
  parameter int XCS_OFF = 16,
  parameter int XSS_OFF = 24,
  parameter int TI_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msr_wr,
  input  logic             msr_rd,
  input  logic [IDX_W-1:0] msr_idx,
  input  logic [XLEN-1:0]  msr_wdata_hi,
  input  logic [XLEN-1:0]  msr_wdata_lo,
  output logic [XLEN-1:0]  msr_rdata_hi,
  output logic [XLEN-1:0]  msr_rdata_lo,
  output logic             msr_fault,
  input  logic             enter_req,
  input  logic             exit_req,
  input  logic [RPL_W-1:0] cpl_in,
  input  logic [XLEN-1:0]  gpr_edx,
  input  logic [XLEN-1:0]  gpr_ecx,
  output logic             xfer_valid,
  output logic             xfer_fault,
  output logic [SEL_W-1:0] new_cs,
  output logic [SEL_W-1:0] new_ss,
  output logic [XLEN-1:0]  new_eip,
  output logic [XLEN-1:0]  new_esp,
  output logic [RPL_W-1:0] new_cpl
);
  localparam logic [RPL_W-1:0] RING0 = '0;
  localparam logic [RPL_W-1:0] RING_USER = '1;

  logic [SEL_W-1:0] cs_q;
  logic [XLEN-1:0]  esp_q, eip_q;

  wire hit_cs  = (msr_idx == IDX_CS);
  wire hit_esp = (msr_idx == IDX_ESP);
  wire hit_eip = (msr_idx == IDX_EIP);
  wire idx_ok  = hit_cs | hit_esp | hit_eip;

  logic [XLEN-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cs)  rd_mux = XLEN'(cs_q);
    if (hit_esp) rd_mux = esp_q;
    if (hit_eip) rd_mux = eip_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '0;
      esp_q <= '0;
      eip_q <= '0;
    end else if (msr_wr) begin
      if (hit_cs)  cs_q  <= msr_wdata_lo[SEL_W-1:0];
      if (hit_esp) esp_q <= msr_wdata_lo;
      if (hit_eip) eip_q <= msr_wdata_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_rdata_hi <= '0;
      msr_rdata_lo <= '0;
      msr_fault    <= 1'b0;
    end else begin
      msr_fault <= (msr_rd | msr_wr) & ~idx_ok;
      if (msr_rd) begin
        msr_rdata_hi <= '0;
        msr_rdata_lo <= rd_mux;
      end
    end
  end

  wire do_enter = enter_req;
  wire do_exit  = exit_req & ~enter_req;
  wire base_bad = (cs_q[SEL_W-1:TI_BITS] == '0);
  wire deny     = base_bad | (do_exit & (cpl_in != RING0));
  wire go       = (do_enter | do_exit) & ~deny;

  wire [SEL_W-1:0] ss_enter = cs_q + SEL_W'(SS_OFF);
  wire [SEL_W-1:0] cs_exit  = cs_q + SEL_W'(XCS_OFF);
  wire [SEL_W-1:0] ss_exit  = cs_q + SEL_W'(XSS_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_fault <= 1'b0;
      new_cs     <= '0;
      new_ss     <= '0;
      new_eip    <= '0;
      new_esp    <= '0;
      new_cpl    <= '0;
    end else begin
      xfer_valid <= go;
      xfer_fault <= (do_enter | do_exit) & deny;
      if (go && do_enter) begin
        new_cs  <= cs_q;
        new_ss  <= ss_enter;
        new_eip <= eip_q;
        new_esp <= esp_q;
        new_cpl <= RING0;
      end else if (go) begin
        new_cs  <= {cs_exit[SEL_W-1:RPL_W], RING_USER};
        new_ss  <= {ss_exit[SEL_W-1:RPL_W], RING_USER};
        new_eip <= gpr_edx;
        new_esp <= gpr_ecx;
        new_cpl <= RING_USER;
      end
    end
  end

  // R7
  xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_valid && xfer_fault));

  // R7
  exit_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req && !enter_req && cpl_in != RING0) |=> (xfer_fault && !xfer_valid));

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fault |-> ($stable(new_cs) && $stable(new_ss) && $stable(new_eip) && $stable(new_esp)));

  // R6
  user_rpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && new_cpl == RING_USER) |-> (new_cs[RPL_W-1:0] == RING_USER && new_ss[RPL_W-1:0] == RING_USER));

  // R5
  ss_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (new_ss == new_cs + SEL_W'(SS_OFF)));

  // R3
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((msr_wr || msr_rd) && !idx_ok) |=> msr_fault);

  // R9
  enter_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && exit_req && !base_bad) |=> (xfer_valid && new_cpl == RING0));
endmodule

// File: tb/sim_sysfast_unit.sv
`timescale 1ns/1ps
module sim_sysfast_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        msr_wr = 1'b0, msr_rd = 1'b0;
  logic [31:0] msr_idx = '0, msr_wdata_hi = '0, msr_wdata_lo = '0;
  logic [31:0] msr_rdata_hi, msr_rdata_lo;
  logic        msr_fault;
  logic        enter_req = 1'b0, exit_req = 1'b0;
  logic [1:0]  cpl_in = '0;
  logic [31:0] gpr_edx = '0, gpr_ecx = '0;
  logic        xfer_valid, xfer_fault;
  logic [15:0] new_cs, new_ss;
  logic [31:0] new_eip, new_esp;
  logic [1:0]  new_cpl;

  sysfast_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .msr_wr(msr_wr), .msr_rd(msr_rd), .msr_idx(msr_idx),
    .msr_wdata_hi(msr_wdata_hi), .msr_wdata_lo(msr_wdata_lo),
    .msr_rdata_hi(msr_rdata_hi), .msr_rdata_lo(msr_rdata_lo), .msr_fault(msr_fault),
    .enter_req(enter_req), .exit_req(exit_req), .cpl_in(cpl_in),
    .gpr_edx(gpr_edx), .gpr_ecx(gpr_ecx),
    .xfer_valid(xfer_valid), .xfer_fault(xfer_fault),
    .new_cs(new_cs), .new_ss(new_ss), .new_eip(new_eip), .new_esp(new_esp), .new_cpl(new_cpl)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_cs = '0;
  logic [31:0] m_esp = '0, m_eip = '0;
  logic [15:0] h_cs = '0, h_ss = '0;
  logic [31:0] h_eip = '0, h_esp = '0;
  logic [1:0]  h_cpl = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [31:0] idx, input logic [31:0] hi,
                     input logic [31:0] lo, input bit en, input bit ex, input logic [1:0] cpl,
                     input logic [31:0] edx, input logic [31:0] ecx);
    @(negedge clk);
    msr_wr = wr; msr_rd = rd; msr_idx = idx; msr_wdata_hi = hi; msr_wdata_lo = lo;
    enter_req = en; exit_req = ex; cpl_in = cpl; gpr_edx = edx; gpr_ecx = ecx;
    @(negedge clk);
    msr_wr = 0; msr_rd = 0; enter_req = 0; exit_req = 0;
  endtask

  function automatic bit valid_idx(input logic [31:0] idx);
    return idx == 32'h174 || idx == 32'h175 || idx == 32'h176;
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] idx);
    if (idx == 32'h174) return {16'h0, m_cs};
    if (idx == 32'h175) return m_esp;
    if (idx == 32'h176) return m_eip;
    return 32'h0;
  endfunction

  task automatic wr_msr(input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] lo, input string req);
    cyc(1, 0, idx, hi, lo, 0, 0, 0, 0, 0);
    if (idx == 32'h174) m_cs = lo[15:0];
    if (idx == 32'h175) m_esp = lo;
    if (idx == 32'h176) m_eip = lo;
    chk(req, "wr fault", {63'h0, msr_fault}, {63'h0, !valid_idx(idx)});
  endtask

  task automatic rd_msr(input logic [31:0] idx, input string req);
    cyc(0, 1, idx, 0, 0, 0, 0, 0, 0, 0);
    chk(req, "rd data", {msr_rdata_hi, msr_rdata_lo}, {32'h0, model_rd(idx)});
    chk(req, "rd fault", {63'h0, msr_fault}, {63'h0, !valid_idx(idx)});
  endtask

  task automatic check_outs(input string req);
    chk(req, "cs", {48'h0, new_cs}, {48'h0, h_cs});
    chk(req, "ss", {48'h0, new_ss}, {48'h0, h_ss});
    chk(req, "eip/esp", {new_eip, new_esp}, {h_eip, h_esp});
    chk(req, "cpl", {62'h0, new_cpl}, {62'h0, h_cpl});
  endtask

  task automatic xfer(input bit en, input bit ex, input logic [1:0] cpl,
                      input logic [31:0] edx, input logic [31:0] ecx, input string req);
    bit use_ex, bad;
    logic [15:0] a, b;
    use_ex = ex && !en;
    bad = (m_cs[15:3] == 13'h0) || (use_ex && cpl != 2'd0);
    cyc(0, 0, 0, 0, 0, en, ex, cpl, edx, ecx);
    if (bad) begin
      chk(req, "fault/valid", {62'h0, xfer_fault, xfer_valid}, 64'h2);
    end else begin
      if (en) begin
        h_cs = m_cs; h_ss = m_cs + 16'd8; h_eip = m_eip; h_esp = m_esp; h_cpl = 2'd0;
      end else begin
        a = m_cs + 16'd16; b = m_cs + 16'd24;
        h_cs = {a[15:2], 2'b11}; h_ss = {b[15:2], 2'b11}; h_eip = edx; h_esp = ecx; h_cpl = 2'd3;
      end
      chk(req, "fault/valid", {62'h0, xfer_fault, xfer_valid}, 64'h1);
    end
    check_outs(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "outs in reset", {new_eip, new_esp}, 64'h0);
    chk("R1", "sel in reset", {28'h0, new_cs, new_ss, new_cpl, xfer_valid, xfer_fault}, 64'h0);
    chk("R1", "msr in reset", {msr_rdata_hi, msr_rdata_lo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after release", {27'h0, new_cs, new_ss, new_cpl, xfer_valid, xfer_fault, msr_fault}, 64'h0);
    for (int i = 0; i < 3; i++) rd_msr(32'h174 + i, "R1");

    // R2 writes and readback, high word ignored
    wr_msr(32'h174, 32'hDEAD_BEEF, 32'hABCD_1238, "R2");
    wr_msr(32'h175, 32'h1111_1111, 32'h8000_0FF0, "R2");
    wr_msr(32'h176, 32'h2222_2222, 32'hC010_2030, "R2");
    for (int i = 0; i < 3; i++) rd_msr(32'h174 + i, "R2");

    // R3 sweep of invalid indices
    for (int i = 0; i < 20; i++) begin
      logic [31:0] idx;
      idx = (i < 16) ? 32'h170 + i : (i == 16 ? 32'h0 : (i == 17 ? 32'hFFFF_FFFF : 32'h1174 + i));
      if (!valid_idx(idx)) begin
        wr_msr(idx, 32'h5A5A_5A5A, 32'hA5A5_A5A5, "R3");
        rd_msr(idx, "R3");
      end
    end
    for (int i = 0; i < 3; i++) rd_msr(32'h174 + i, "R3");

    // R4 read and write same cycle
    cyc(1, 1, 32'h176, 0, 32'h0BAD_F00D, 0, 0, 0, 0, 0);
    chk("R4", "old value", {32'h0, msr_rdata_lo}, {32'h0, m_eip});
    m_eip = 32'h0BAD_F00D;
    rd_msr(32'h176, "R4");

    // R5 R6 R7 R8 sweep over selector bases
    for (int i = 0; i < 48; i++) begin
      logic [15:0] base;
      base = 16'(i * 1367 + 5);
      if (i < 4) base = 16'(i * 2 + 1);
      if (i == 4) base = 16'hFFF8;
      if (i == 5) base = 16'hFFEB;
      wr_msr(32'h174, 32'h0, {16'hFFFF, base}, "R2");
      wr_msr(32'h175, 32'h0, 32'h1000_0000 + i, "R2");
      wr_msr(32'h176, 32'h0, 32'h2000_0000 + i * 3, "R2");
      xfer(1, 0, 2'(i), 0, 0, (base[15:3] == 0) ? "R8" : "R5");
      xfer(0, 1, 2'd0, 32'h3000_0000 + i, 32'h4000_0000 + i, (base[15:3] == 0) ? "R8" : "R6");
      xfer(0, 1, 2'(1 + i % 3), 32'h5, 32'h6, "R7");
    end

    // R9 simultaneous enter and exit
    wr_msr(32'h174, 32'h0, 32'h0000_0048, "R2");
    xfer(0, 1, 2'd0, 32'h77, 32'h88, "R6");
    xfer(1, 1, 2'd0, 32'h99, 32'hAA, "R9");
    xfer(1, 1, 2'd3, 32'h99, 32'hAA, "R9");

    // R10 enter with concurrent write uses old values
    cyc(1, 0, 32'h174, 0, 32'h0000_0120, 1, 0, 0, 0, 0);
    h_cs = m_cs; h_ss = m_cs + 16'd8; h_eip = m_eip; h_esp = m_esp; h_cpl = 2'd0;
    m_cs = 16'h0120;
    chk("R10", "valid", {63'h0, xfer_valid}, 64'h1);
    check_outs("R10");
    xfer(1, 0, 2'd0, 0, 0, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule